// File: doc/BRIEF.md
# Multithreaded Pipeline Thread Scheduler

This block chooses, on every host clock cycle, which of up to 64 simulated-core contexts sends its next instruction into a single shared host pipeline. The pipeline has five stages: fetch, decode, register access, memory and exception. The scheduler walks the enabled contexts in rotating order. It skips any context that is still inside the pipeline, any context that is serving a stall, and any context whose index is at or above the runtime active count. Because a context that is still in flight is never picked, no two pipeline stages ever hold the same context, so the host pipeline needs no forwarding.

For each context the block keeps a fetch address and a stall countdown. The stall countdown is loaded by an external timing model. The block also keeps a 64-bit target-cycle counter for each context. That counter moves only when an instruction of the context retires or when the timing model charges it stall cycles. It does not move with host clock cycles, so target time stays separate from host time.

A pipeline occupancy shadow reports which context sits in each stage. A fetch-slot state machine has three states:
- HALT: the run input is low.
- ISSUE: a context was placed in fetch.
- BUBBLE: no context was eligible, and the cycle was counted as idle.

On every cycle the next state is chosen the same way. If run is low, the next state is HALT. If run is high and some context is eligible, the next state is ISSUE. Otherwise the next state is BUBBLE. Any state can move to any state.

Top module: `thread_issue_sched`

## Requirements
- R1: After reset every stage is empty and fetch_valid is 0. idle_cycles is 0, every target-cycle counter is 0, and every context's fetch address equals the boot address (256).
- R2: Contexts are picked in ascending index order. The search starts just after the last context issued and wraps from the highest index back to 0. The first pick after reset is context 0. A pick made at a clock edge appears on fetch_valid, fetch_tid and fetch_pc right after that edge.
- R3: A context that sits in fetch, decode, register access or memory is not picked. A context in the exception stage may be picked. As a result, no two stages hold the same context.
- R4: A context whose index is at or above active_cnt never issues. With active_cnt equal to 0, nothing issues.
- R5: A stall request names a context and a count K. The count is taken at the clock edge where stall_valid is high. That context is then skipped at the K selection edges that follow, and it may be picked again at the edge after those.
- R6: A context's target-cycle counter gains 1 when one of its instructions leaves the exception stage (retire_valid with retire_tid). It gains K when a stall request of count K is taken for it. rd_cycles shows the counter of context rd_tid with no clock delay.
- R7: An issue delivers the context's current fetch address on fetch_pc and then advances that address by 4. A redirect replaces the context's address, and the next issue of that context uses the new value.
- R8: When run is high and no context is eligible, the fetch slot holds a bubble (fetch_valid 0) and idle_cycles increases by 1. While run is low, nothing issues and idle_cycles does not change.
- R9: On every clock, each stage takes the previous stage's content. stage_valid bit k and stage_tid bits [6k+5:6k] describe stage k, where 0 is fetch and 4 is exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Allows issue when high |
| active_cnt | input | 7 | Number of enabled contexts (0 to 64) |
| stall_valid | input | 1 | Stall request from the timing model |
| stall_tid | input | 6 | Context the stall applies to |
| stall_cycles | input | 16 | Stall length in target cycles |
| redir_valid | input | 1 | Fetch-address redirect request |
| redir_tid | input | 6 | Context to redirect |
| redir_pc | input | 32 | New fetch address |
| fetch_valid | output | 1 | Fetch stage holds an instruction |
| fetch_tid | output | 6 | Context in fetch |
| fetch_pc | output | 32 | Fetch address of that instruction |
| stage_valid | output | 5 | Occupancy of each stage, bit 0 is fetch |
| stage_tid | output | 30 | Context in each stage, 6 bits per stage |
| retire_valid | output | 1 | Exception stage occupied; it retires at the next edge |
| retire_tid | output | 6 | Context in the exception stage |
| rd_tid | input | 6 | Context whose target-cycle counter is read |
| rd_cycles | output | 64 | Target-cycle counter of rd_tid |
| idle_cycles | output | 64 | Count of bubble cycles |

## Verification
A pick made at one rising edge shows on the fetch outputs straight after that edge. The same instruction appears in stage k exactly k edges later. A stall count taken at an edge first takes effect at the following edge's pick.

The driver places every expected fetch item in a queue and then raises run at a falling edge. From that point the monitor pops one item per cycle, sampling 5 ns after each rising edge, so item n belongs to the pick made at the n-th edge after run was raised. Each sample also checks every stage against the fetch contents seen k samples earlier. Counter reads happen only after run has been low long enough for the pipeline to drain, and each is compared with the issues the monitor saw plus the stall cycles the bench charged.

// File: rtl/tis_pkg.sv
package tis_pkg;

    // Stage order of the host pipeline, oldest stage last.
    localparam int NSTAGES = 5;

    typedef enum logic [2:0] {
        STG_FETCH  = 3'd0,
        STG_DECODE = 3'd1,
        STG_REGRD  = 3'd2,
        STG_MEM    = 3'd3,
        STG_EXC    = 3'd4
    } stage_e;

    // Content class of the fetch slot.
    typedef enum logic [1:0] {
        S_HALT   = 2'd0,
        S_ISSUE  = 2'd1,
        S_BUBBLE = 2'd2
    } fetch_state_e;

endpackage

// File: rtl/tis_arbiter.sv
module tis_arbiter #(
    parameter int NTHREADS = 64,
    localparam int TW = $clog2(NTHREADS)
) (
    input  logic [NTHREADS-1:0] elig,
    input  logic [TW-1:0]       last_tid,
    output logic                pick_valid,
    output logic [TW-1:0]       pick_tid
);

    // Rotating search starting one past the last issued context.
    // NTHREADS is a power of two, so index arithmetic wraps naturally.
    always_comb begin
        pick_valid = 1'b0;
        pick_tid   = '0;
        for (int i = 0; i < NTHREADS; i++) begin
            logic [TW-1:0] idx;
            idx = last_tid + TW'(i + 1);
            if (!pick_valid && elig[idx]) begin
                pick_valid = 1'b1;
                pick_tid   = idx;
            end
        end
    end

endmodule

// File: rtl/tis_thread_table.sv
module tis_thread_table #(
    parameter int NTHREADS = 64,
    parameter int PCW = 32,
    parameter int SW = 16,
    parameter int CW = 64,
    parameter int unsigned BOOT_PC = 256,
    localparam int TW = $clog2(NTHREADS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue_valid,
    input  logic [TW-1:0]       issue_tid,
    output logic [PCW-1:0]      issue_pc,
    input  logic                redir_valid,
    input  logic [TW-1:0]       redir_tid,
    input  logic [PCW-1:0]      redir_pc,
    input  logic                stall_valid,
    input  logic [TW-1:0]       stall_tid,
    input  logic [SW-1:0]       stall_cycles,
    input  logic                retire_valid,
    input  logic [TW-1:0]       retire_tid,
    output logic [NTHREADS-1:0] stall_clear,
    input  logic [TW-1:0]       rd_tid,
    output logic [CW-1:0]       rd_cycles
);

    logic [PCW-1:0] pc_q    [NTHREADS];
    logic [SW-1:0]  stall_q [NTHREADS];
    logic [CW-1:0]  cyc_q   [NTHREADS];

    for (genvar t = 0; t < NTHREADS; t++) begin : g_ctx
        logic hit_issue, hit_redir, hit_stall, hit_retire;

        assign hit_issue  = issue_valid  && (issue_tid  == TW'(t));
        assign hit_redir  = redir_valid  && (redir_tid  == TW'(t));
        assign hit_stall  = stall_valid  && (stall_tid  == TW'(t));
        assign hit_retire = retire_valid && (retire_tid == TW'(t));

        // Fetch address: a redirect wins over the post-issue advance.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pc_q[t] <= PCW'(BOOT_PC);
            end else if (hit_redir) begin
                pc_q[t] <= redir_pc;
            end else if (hit_issue) begin
                pc_q[t] <= pc_q[t] + PCW'(4);
            end
        end

        // Stall countdown: load on request, otherwise count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stall_q[t] <= '0;
            end else if (hit_stall) begin
                stall_q[t] <= stall_cycles;
            end else if (stall_q[t] != '0) begin
                stall_q[t] <= stall_q[t] - SW'(1);
            end
        end

        // Target time: one per retired instruction plus charged stalls.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cyc_q[t] <= '0;
            end else if (hit_retire || hit_stall) begin
                cyc_q[t] <= cyc_q[t] + CW'(hit_retire)
                          + (hit_stall ? CW'(stall_cycles) : CW'(0));
            end
        end

        assign stall_clear[t] = (stall_q[t] == '0);
    end

    assign issue_pc  = pc_q[issue_tid];
    assign rd_cycles = cyc_q[rd_tid];

endmodule

// File: rtl/tis_stage_shadow.sv
module tis_stage_shadow #(
    parameter int NTHREADS = 64,
    parameter int DEPTH = 5,
    localparam int TW = $clog2(NTHREADS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            head_valid,
    input  logic [TW-1:0]   head_tid,
    output logic [DEPTH-1:0] st_valid,
    output logic [TW-1:0]   st_tid [DEPTH]
);

    // Stage 0 is the fetch slot held by the scheduler itself.
    assign st_valid[0] = head_valid;
    assign st_tid[0]   = head_tid;

    for (genvar k = 1; k < DEPTH; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_valid[k] <= 1'b0;
                st_tid[k]   <= '0;
            end else begin
                st_valid[k] <= st_valid[k-1];
                st_tid[k]   <= st_tid[k-1];
            end
        end
    end

endmodule

// File: rtl/thread_issue_sched.sv
module thread_issue_sched
    import tis_pkg::*;
#(
    parameter int NTHREADS = 64,
    parameter int PCW = 32,
    parameter int SW = 16,
    parameter int CW = 64,
    parameter int unsigned BOOT_PC = 256,
    localparam int TW = $clog2(NTHREADS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic [TW:0]           active_cnt,
    input  logic                  stall_valid,
    input  logic [TW-1:0]         stall_tid,
    input  logic [SW-1:0]         stall_cycles,
    input  logic                  redir_valid,
    input  logic [TW-1:0]         redir_tid,
    input  logic [PCW-1:0]        redir_pc,
    output logic                  fetch_valid,
    output logic [TW-1:0]         fetch_tid,
    output logic [PCW-1:0]        fetch_pc,
    output logic [NSTAGES-1:0]    stage_valid,
    output logic [NSTAGES*TW-1:0] stage_tid,
    output logic                  retire_valid,
    output logic [TW-1:0]         retire_tid,
    input  logic [TW-1:0]         rd_tid,
    output logic [CW-1:0]         rd_cycles,
    output logic [CW-1:0]         idle_cycles
);

    fetch_state_e state_q, state_d;

    logic [TW-1:0]       last_tid_q;
    logic [NTHREADS-1:0] elig, busy, enabled, stall_clear;
    logic                pick_valid;
    logic [TW-1:0]       pick_tid;
    logic [PCW-1:0]      pick_pc;
    logic [NSTAGES-1:0]  st_valid;
    logic [TW-1:0]       st_tid [NSTAGES];

    // Eligibility: enabled, not stalled, not in fetch..memory.
    always_comb begin
        for (int t = 0; t < NTHREADS; t++) begin
            enabled[t] = ((TW+1)'(t) < active_cnt);
            busy[t]    = 1'b0;
            for (int k = 0; k < NSTAGES - 1; k++) begin
                if (st_valid[k] && (st_tid[k] == TW'(t))) begin
                    busy[t] = 1'b1;
                end
            end
            elig[t] = enabled[t] && stall_clear[t] && !busy[t];
        end
    end

    tis_arbiter #(
        .NTHREADS(NTHREADS)
    ) u_arb (
        .elig      (elig),
        .last_tid  (last_tid_q),
        .pick_valid(pick_valid),
        .pick_tid  (pick_tid)
    );

    // Next-state logic of the fetch slot.
    always_comb begin
        if (!run) begin
            state_d = S_HALT;
        end else if (pick_valid) begin
            state_d = S_ISSUE;
        end else begin
            state_d = S_BUBBLE;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // Fetch-slot payload, rotation pointer and idle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_tid   <= '0;
            fetch_pc    <= '0;
            last_tid_q  <= TW'(NTHREADS - 1);
            idle_cycles <= '0;
        end else begin
            if (state_d == S_ISSUE) begin
                fetch_tid  <= pick_tid;
                fetch_pc   <= pick_pc;
                last_tid_q <= pick_tid;
            end
            if (state_d == S_BUBBLE) begin
                idle_cycles <= idle_cycles + CW'(1);
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        unique case (state_q)
            S_ISSUE:  fetch_valid = 1'b1;
            S_BUBBLE: fetch_valid = 1'b0;
            S_HALT:   fetch_valid = 1'b0;
            default:  fetch_valid = 1'b0;
        endcase
    end

    tis_stage_shadow #(
        .NTHREADS(NTHREADS),
        .DEPTH   (NSTAGES)
    ) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .head_valid(fetch_valid),
        .head_tid  (fetch_tid),
        .st_valid  (st_valid),
        .st_tid    (st_tid)
    );

    assign retire_valid = st_valid[NSTAGES-1];
    assign retire_tid   = st_tid[NSTAGES-1];
    assign stage_valid  = st_valid;

    for (genvar k = 0; k < NSTAGES; k++) begin : g_flat
        assign stage_tid[k*TW +: TW] = st_tid[k];
    end

    tis_thread_table #(
        .NTHREADS(NTHREADS),
        .PCW     (PCW),
        .SW      (SW),
        .CW      (CW),
        .BOOT_PC (BOOT_PC)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (state_d == S_ISSUE),
        .issue_tid   (pick_tid),
        .issue_pc    (pick_pc),
        .redir_valid (redir_valid),
        .redir_tid   (redir_tid),
        .redir_pc    (redir_pc),
        .stall_valid (stall_valid),
        .stall_tid   (stall_tid),
        .stall_cycles(stall_cycles),
        .retire_valid(retire_valid),
        .retire_tid  (retire_tid),
        .stall_clear (stall_clear),
        .rd_tid      (rd_tid),
        .rd_cycles   (rd_cycles)
    );

endmodule

// File: rtl/tis_checker.sv
module tis_checker #(
    parameter int TW = 6,
    parameter int NSTAGES = 5,
    parameter int SW = 16,
    parameter int CW = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  run,
    input logic [TW:0]           active_cnt,
    input logic                  stall_valid,
    input logic [TW-1:0]         stall_tid,
    input logic [SW-1:0]         stall_cycles,
    input logic                  fetch_valid,
    input logic [TW-1:0]         fetch_tid,
    input logic [NSTAGES-1:0]    stage_valid,
    input logic [NSTAGES*TW-1:0] stage_tid,
    input logic [CW-1:0]         idle_cycles
);

    for (genvar k = 0; k < NSTAGES - 1; k++) begin : g_pair
        AST_NO_ADJ_DUP: assert property (@(posedge clk) disable iff (!rst_n)
            (stage_valid[k] && stage_valid[k+1]) |-> (stage_tid[k*TW +: TW] != stage_tid[(k+1)*TW +: TW])); // R3

        AST_STAGE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((stage_valid[k+1] == $past(stage_valid[k])) && (!stage_valid[k+1] || (stage_tid[(k+1)*TW +: TW] == $past(stage_tid[k*TW +: TW]))))); // R9
    end

    AST_INACTIVE_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> ({1'b0, fetch_tid} < $past(active_cnt))); // R4

    AST_HALT_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !fetch_valid); // R8

    AST_IDLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(run) && !fetch_valid) |-> (idle_cycles == $past(idle_cycles) + CW'(1))); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(run)) |-> $stable(idle_cycles)); // R8

    AST_STALL_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_valid && (stall_cycles != '0)) |=> ##1 !(fetch_valid && (fetch_tid == $past(stall_tid, 2)))); // R5

endmodule

bind thread_issue_sched tis_checker #(
    .TW     (TW),
    .NSTAGES(tis_pkg::NSTAGES),
    .SW     (SW),
    .CW     (CW)
) u_tis_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .active_cnt  (active_cnt),
    .stall_valid (stall_valid),
    .stall_tid   (stall_tid),
    .stall_cycles(stall_cycles),
    .fetch_valid (fetch_valid),
    .fetch_tid   (fetch_tid),
    .stage_valid (stage_valid),
    .stage_tid   (stage_tid),
    .idle_cycles (idle_cycles)
);

// File: tb/test_thread_issue_sched.sv
`timescale 1ns/1ps
module test_thread_issue_sched;

    localparam int TW = 6;
    localparam int BOOT = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [6:0]  active_cnt = '0;
    logic        stall_valid = 1'b0;
    logic [5:0]  stall_tid = '0;
    logic [15:0] stall_cycles = '0;
    logic        redir_valid = 1'b0;
    logic [5:0]  redir_tid = '0;
    logic [31:0] redir_pc = '0;
    logic        fetch_valid;
    logic [5:0]  fetch_tid;
    logic [31:0] fetch_pc;
    logic [4:0]  stage_valid;
    logic [29:0] stage_tid;
    logic        retire_valid;
    logic [5:0]  retire_tid;
    logic [5:0]  rd_tid = '0;
    logic [63:0] rd_cycles;
    logic [63:0] idle_cycles;

    thread_issue_sched i_thread_issue_sched (
        .clk(clk), .rst_n(rst_n), .run(run), .active_cnt(active_cnt),
        .stall_valid(stall_valid), .stall_tid(stall_tid), .stall_cycles(stall_cycles),
        .redir_valid(redir_valid), .redir_tid(redir_tid), .redir_pc(redir_pc),
        .fetch_valid(fetch_valid), .fetch_tid(fetch_tid), .fetch_pc(fetch_pc),
        .stage_valid(stage_valid), .stage_tid(stage_tid),
        .retire_valid(retire_valid), .retire_tid(retire_tid),
        .rd_tid(rd_tid), .rd_cycles(rd_cycles), .idle_cycles(idle_cycles)
    );

    always #10 clk = ~clk;

    typedef struct {
        bit    v;
        int    tid;
        int    pc;
        int    idle;
        string tag;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad = 0;
    int issued [64];
    int charged [64];
    bit hv [5];
    int ht [5];
    int hcnt = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input bit v, input int tid, input int pc,
                        input int idle, input string tag);
        item_t it;
        it.v = v; it.tid = tid; it.pc = pc; it.idle = idle; it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: one sample 5 ns after every rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (!rst_n) begin
                hcnt = 0;
                for (int t = 0; t < 64; t++) begin
                    issued[t] = 0;
                end
            end else begin
                for (int j = 4; j > 0; j--) begin
                    hv[j] = hv[j-1];
                    ht[j] = ht[j-1];
                end
                hv[0] = fetch_valid;
                ht[0] = int'(fetch_tid);
                hcnt++;
                if (fetch_valid) issued[fetch_tid]++;
                // R9: stage k shows what fetch held k samples earlier
                for (int k = 1; k < 5; k++) begin
                    if (hcnt > k) begin
                        check(stage_valid[k] == hv[k], "R9", "stage valid",
                              longint'(stage_valid[k]), longint'(hv[k]));
                        if (hv[k])
                            check(int'(stage_tid[k*TW +: TW]) == ht[k], "R9", "stage tid",
                                  longint'(stage_tid[k*TW +: TW]), longint'(ht[k]));
                    end
                end
                if (q.size() > 0) begin
                    item_t e;
                    e = q.pop_front();
                    check(fetch_valid == e.v, e.tag, "fetch_valid",
                          longint'(fetch_valid), longint'(e.v));
                    if (e.v) begin
                        check(int'(fetch_tid) == e.tid, e.tag, "fetch_tid",
                              longint'(fetch_tid), longint'(e.tid));
                        check(int'(fetch_pc) == e.pc, "R7", "fetch_pc",
                              longint'(fetch_pc), longint'(e.pc));
                    end
                    check(int'(idle_cycles) == e.idle, "R8", "idle_cycles",
                          longint'(idle_cycles), longint'(e.idle));
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        run = 1'b0;
        for (int t = 0; t < 64; t++) charged[t] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_stop_drain();
        while (q.size() > 0) @(negedge clk);
        run = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic check_counters(input int n);
        for (int t = 0; t < n; t++) begin
            rd_tid = 6'(t);
            #1;
            check(rd_cycles == 64'(issued[t] + charged[t]), "R6", "rd_cycles",
                  longint'(rd_cycles), longint'(issued[t] + charged[t]));
        end
    endtask

    initial begin
        #(200000 * 20);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        repeat (2) @(negedge clk);
        check(fetch_valid == 1'b0, "R1", "fetch_valid", longint'(fetch_valid), 0);
        check(stage_valid == 5'b0, "R1", "stage_valid", longint'(stage_valid), 0);
        check(idle_cycles == 64'd0, "R1", "idle_cycles", longint'(idle_cycles), 0);
        rd_tid = 6'd17;
        #1;
        check(rd_cycles == 64'd0, "R1", "rd_cycles", longint'(rd_cycles), 0);

        // R2 R3 R8: four contexts, bubble every fifth slot
        active_cnt = 7'd4;
        for (int r = 0; r < 2; r++) begin
            for (int t = 0; t < 4; t++) push(1, t, BOOT + 4*r, r, "R2");
            push(0, 0, 0, r + 1, "R3");
        end
        run = 1'b1;
        wait_stop_drain();
        check_counters(5);
        check(issued[4] == 0, "R4", "issues of context 4", longint'(issued[4]), 0);

        // R2 R7: eight contexts, context 3 redirected before run
        do_reset();
        active_cnt = 7'd8;
        redir_valid = 1'b1;
        redir_tid = 6'd3;
        redir_pc = 32'h1000;
        @(negedge clk);
        redir_valid = 1'b0;
        for (int r = 0; r < 2; r++) begin
            for (int t = 0; t < 8; t++)
                push(1, t, (t == 3) ? (32'h1000 + 4*r) : (BOOT + 4*r), 0, "R2");
        end
        run = 1'b1;
        wait_stop_drain();
        check_counters(8);

        // R5 R6: six contexts, context 1 stalled for 3 at the first edge
        do_reset();
        active_cnt = 7'd6;
        push(1, 0, BOOT, 0, "R5");
        push(1, 2, BOOT, 0, "R5");
        push(1, 3, BOOT, 0, "R5");
        push(1, 4, BOOT, 0, "R5");
        push(1, 5, BOOT, 0, "R5");
        push(1, 0, BOOT + 4, 0, "R5");
        push(1, 1, BOOT, 0, "R5");
        push(1, 2, BOOT + 4, 0, "R5");
        push(1, 3, BOOT + 4, 0, "R5");
        stall_valid = 1'b1;
        stall_tid = 6'd1;
        stall_cycles = 16'd3;
        charged[1] = 3;
        run = 1'b1;
        @(negedge clk);
        stall_valid = 1'b0;
        wait_stop_drain();
        check_counters(6);

        // R3 R8: one context waits for its own instruction to clear memory
        do_reset();
        active_cnt = 7'd1;
        push(1, 0, BOOT, 0, "R3");
        for (int b = 1; b <= 4; b++) push(0, 0, 0, b, "R3");
        push(1, 0, BOOT + 4, 4, "R3");
        push(0, 0, 0, 5, "R3");
        run = 1'b1;
        wait_stop_drain();
        check_counters(2);

        // R4 R8: no context enabled, idle frozen once halted
        do_reset();
        active_cnt = 7'd0;
        for (int b = 1; b <= 3; b++) push(0, 0, 0, b, "R4");
        run = 1'b1;
        while (q.size() > 0) @(negedge clk);
        run = 1'b0;
        repeat (3) @(negedge clk);
        check(idle_cycles == 64'd3, "R8", "idle while halted", longint'(idle_cycles), 3);
        check(fetch_valid == 1'b0, "R8", "fetch while halted", longint'(fetch_valid), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule